// File: doc/BRIEF.md
# Dual 8-bit Interval Timer

This block contains two independent interval timers, A and B, each built from a clock-rate selector, an up-counter, a reference register and an equality compare. While a timer is enabled, its counter advances once per selected tick. When a tick arrives with the counter equal to the reference value, the counter returns to zero and a sticky pending flag is set. The flag stays set until software writes a clear strobe. Each timer drives an interrupt line, which is its pending flag gated by an interrupt-enable bit.

Software reaches the four registers through a single-cycle write port and a combinational read port selected by a 2-bit address. Address 0 is the A control register, 1 the A reference, 2 the B control register and 3 the B reference. The live counter values are brought out on their own output ports.

Both timers share one free-running prescaler, which gives tick rates of the system clock divided by 256, 64, 8 or 1. Timer A can instead count rising edges of an asynchronous external clock pin. That pin is passed through a two-flop synchronizer and an edge detector. All state lives in the system clock domain, and the reset is asserted asynchronously and released synchronously.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, both counters, all four register read values, and both interrupt outputs are 0.
- R2: Control bits [2:1] select the tick rate: 00 gives clk/256, 01 gives clk/64, 10 gives clk/8 and 11 gives every clock. An enabled counter advances by exactly one per tick.
- R3: A tick that finds the counter equal to the reference sets the counter to 0 and the pending flag to 1, so the match period is reference+1 ticks. The flag is visible on control read bit 7 one clock after the match tick.
- R4: The pending flag stays set until a control write with bit 6 set clears it. A match in the same cycle as the clear keeps the flag set.
- R5: Each interrupt output is high exactly when that timer's pending flag is set and its control bit 4 (interrupt enable) is 1.
- R6: Writing control bit 5 as 1 zeroes the counter in that cycle, overriding any tick. Control bits 5 and 6 always read back as 0.
- R7: With control bit 0 (enable) at 0, the counter keeps its value and no match or pending flag arises, even when counter and reference are equal.
- R8: Timer A with control bit 3 set counts one per synchronized rising edge of `ext_clk_a` instead of prescaler ticks. It does not count while the pin is idle.
- R9: A write to address 1 or 3 loads that timer's reference, which reads back unchanged and is used from the next tick onward.
- R10: Timer B has no external clock choice: its control bit 3 ignores writes and reads 0. Activity on either timer never changes the other timer's counter or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_a | input | 1 | Asynchronous external count clock for timer A |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 2 | Register select: 0 A control, 1 A reference, 2 B control, 3 B reference |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data of the register selected by addr |
| cnt_a | output | 8 | Current timer A counter |
| cnt_b | output | 8 | Current timer B counter |
| irq_a | output | 1 | Timer A interrupt request |
| irq_b | output | 1 | Timer B interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and a prescaler with taps at 8, 6, 3 and 0 bits. With these values the slowest rate, one tick per 256 clocks, can be measured edge to edge in a few hundred cycles. An 8-bit reference keeps the match period short enough to watch several wraps. The external path is driven with slow pulses, so the two-flop delay settles before each count is checked.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned NUM_DIV = 4;
  localparam int unsigned DIV_W   = $clog2(NUM_DIV);

  // control register bit positions
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned DIV_LO   = 1;
  localparam int unsigned DIV_HI   = DIV_LO + DIV_W - 1;
  localparam int unsigned EXT_BIT  = 3;
  localparam int unsigned IE_BIT   = 4;
  localparam int unsigned CLR_BIT  = 5;
  localparam int unsigned PCLR_BIT = 6;
  localparam int unsigned PND_BIT  = 7;

  typedef struct packed {
    logic             ie;
    logic             ext;
    logic [DIV_W-1:0] div;
    logic             en;
  } tmr_cfg_t;

  function automatic logic [REG_W-1:0] pack_ctrl(tmr_cfg_t c, logic pnd);
    logic [REG_W-1:0] r;
    r            = '0;
    r[EN_BIT]    = c.en;
    r[DIV_HI:DIV_LO] = c.div;
    r[EXT_BIT]   = c.ext;
    r[IE_BIT]    = c.ie;
    r[PND_BIT]   = pnd;
    return r;
  endfunction
endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler
  import dtmr_pkg::*;
#(
  parameter int unsigned PRE_W          = 8,
  parameter int unsigned TAP [NUM_DIV]  = '{8, 6, 3, 0}
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [NUM_DIV-1:0] tick
);
  logic [PRE_W-1:0] pre_q, pre_d;

  always_comb begin
    pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_tap
    if (TAP[g] == 0) begin : g_every
      assign tick[g] = 1'b1;
    end else begin : g_div
      assign tick[g] = &pre_q[TAP[g]-1:0];
    end
  end
endmodule

// File: rtl/dtmr_edge_sync.sv
module dtmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_in};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
  import dtmr_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter bit          HAS_EXT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DIV-1:0] tick_div,
  input  logic               tick_ext,
  input  logic               ctrl_we,
  input  logic               data_we,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   ctrl_rd,
  output logic [CNT_W-1:0]   ref_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               pnd_o,
  output logic               en_o,
  output logic               irq_o
);
  tmr_cfg_t         cfg_q, cfg_d;
  logic [CNT_W-1:0] ref_q, ref_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pnd_q, pnd_d;
  logic             tick, match, cnt_clr, pnd_clr;

  always_comb begin
    cfg_d = cfg_q;
    if (ctrl_we) begin
      cfg_d.en  = wdata[EN_BIT];
      cfg_d.div = wdata[DIV_HI:DIV_LO];
      cfg_d.ext = HAS_EXT ? wdata[EXT_BIT] : 1'b0;
      cfg_d.ie  = wdata[IE_BIT];
    end
    ref_d   = data_we ? wdata[CNT_W-1:0] : ref_q;
    tick    = cfg_q.ext ? tick_ext : tick_div[cfg_q.div];
    match   = cfg_q.en && tick && (cnt_q == ref_q);
    cnt_clr = ctrl_we && wdata[CLR_BIT];
    pnd_clr = ctrl_we && wdata[PCLR_BIT];

    if (cnt_clr)                 cnt_d = '0;
    else if (match)              cnt_d = '0;
    else if (cfg_q.en && tick)   cnt_d = cnt_q + 1'b1;
    else                         cnt_d = cnt_q;

    if (match)        pnd_d = 1'b1;
    else if (pnd_clr) pnd_d = 1'b0;
    else              pnd_d = pnd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ref_q <= '0;
      cnt_q <= '0;
      pnd_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      ref_q <= ref_d;
      cnt_q <= cnt_d;
      pnd_q <= pnd_d;
    end
  end

  assign ctrl_rd = pack_ctrl(cfg_q, pnd_q);
  assign ref_o   = ref_q;
  assign cnt_o   = cnt_q;
  assign pnd_o   = pnd_q;
  assign en_o    = cfg_q.en;
  assign irq_o   = pnd_q & cfg_q.ie;
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dtmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk_a,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rd_data,
  output logic [CNT_W-1:0] cnt_a,
  output logic [CNT_W-1:0] cnt_b,
  output logic             irq_a,
  output logic             irq_b
);
  localparam int unsigned NUM_TMR = 2;

  logic [1:0]         rst_pipe_q;
  logic               rst_sync_n;
  logic [NUM_DIV-1:0] tick_div;
  logic               tick_ext;
  logic [NUM_TMR-1:0] we_ctrl, we_data, pnd, en, irq;
  logic [REG_W-1:0]   ctrl_rd [NUM_TMR];
  logic [CNT_W-1:0]   ref_v   [NUM_TMR];
  logic [CNT_W-1:0]   cnt_v   [NUM_TMR];
  logic               pnd_a, pnd_b, en_a;
  logic [CNT_W-1:0]   ref_a;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  dtmr_prescaler u_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick_div)
  );

  dtmr_edge_sync #(.STAGES(2)) u_ext (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (ext_clk_a),
    .rise     (tick_ext)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    assign we_ctrl[t] = wr_en && (addr == 2'(2 * t));
    assign we_data[t] = wr_en && (addr == 2'(2 * t + 1));

    dtmr_channel #(
      .CNT_W   (CNT_W),
      .HAS_EXT (t == 0)
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .tick_div (tick_div),
      .tick_ext (tick_ext),
      .ctrl_we  (we_ctrl[t]),
      .data_we  (we_data[t]),
      .wdata    (wdata),
      .ctrl_rd  (ctrl_rd[t]),
      .ref_o    (ref_v[t]),
      .cnt_o    (cnt_v[t]),
      .pnd_o    (pnd[t]),
      .en_o     (en[t]),
      .irq_o    (irq[t])
    );
  end

  always_comb begin
    case (addr)
      2'd0:    rd_data = ctrl_rd[0];
      2'd1:    rd_data = REG_W'(ref_v[0]);
      2'd2:    rd_data = ctrl_rd[1];
      default: rd_data = REG_W'(ref_v[1]);
    endcase
  end

  assign cnt_a = cnt_v[0];
  assign cnt_b = cnt_v[1];
  assign irq_a = irq[0];
  assign irq_b = irq[1];
  assign pnd_a = pnd[0];
  assign pnd_b = pnd[1];
  assign en_a  = en[0];
  assign ref_a = ref_v[0];
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [7:0]       wdata,
  input logic [7:0]       rd_data,
  input logic [CNT_W-1:0] cnt_a,
  input logic [CNT_W-1:0] ref_a,
  input logic             pnd_a,
  input logic             pnd_b,
  input logic             en_a
);
  // R2
  cnt_a_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_a != $past(cnt_a)) |-> (cnt_a == $past(cnt_a) + 1'b1 || cnt_a == '0));

  // R3
  pnd_a_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pnd_a) |-> ($past(cnt_a) == $past(ref_a)));

  // R4
  pnd_a_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pnd_a && !(wr_en && addr == 2'd0 && wdata[6])) |=> pnd_a);

  // R4
  pnd_b_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pnd_b && !(wr_en && addr == 2'd2 && wdata[6])) |=> pnd_b);

  // R6
  strobe_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[0] == 1'b0) |-> (rd_data[6:5] == 2'b00));

  // R7
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_a && !(wr_en && addr == 2'd0)) |=> ($stable(cnt_a) && !$rose(pnd_a)));

  // R10
  b_no_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd2) |-> !rd_data[3]);
endmodule

bind dual_interval_timer dtmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .rd_data (rd_data),
  .cnt_a   (cnt_a),
  .ref_a   (ref_a),
  .pnd_a   (pnd_a),
  .pnd_b   (pnd_b),
  .en_a    (en_a)
);

// File: tb/test_dual_interval_timer.sv
module test_dual_interval_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk_a = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rd_data, cnt_a, cnt_b;
  logic       irq_a, irq_b;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_interval_timer i_dual_interval_timer (
    .clk(clk), .rst_n(rst_n), .ext_clk_a(ext_clk_a), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .cnt_a(cnt_a),
    .cnt_b(cnt_b), .irq_a(irq_a), .irq_b(irq_b)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = 8'd0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 register read", d, 0);
    end
    check("R1 cnt_a", cnt_a, 0);
    check("R1 cnt_b", cnt_b, 0);
    check("R1 irqs", {irq_a, irq_b}, 0);
  endtask

  task automatic t_rate(logic [1:0] code, int exp_period);
    int gap;
    logic [7:0] prev;
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h61 | {5'd0, code, 1'b0});
    prev = cnt_a;
    for (int i = 0; i < 600 && cnt_a == prev; i++) cyc(1);
    prev = cnt_a;
    gap = 0;
    for (int i = 0; i < 600 && cnt_a == prev; i++) begin
      cyc(1);
      gap++;
    end
    check($sformatf("R2 period for code %0d", code), gap, exp_period);
    check("R2 step of one", cnt_a, prev + 8'd1);
  endtask

  task automatic t_match;
    logic [7:0] d;
    wr(2'd1, 8'h05);
    wr(2'd0, 8'h67);
    check("R3 cleared start", cnt_a, 0);
    cyc(5);
    check("R3 counter reaches reference", cnt_a, 5);
    check("R3 no pending before match", irq_a | i_pend_a(), 0);
    cyc(1);
    check("R3 counter wraps to zero", cnt_a, 0);
    rd(2'd0, d);
    check("R3 pending visible", d[7], 1);
    check("R5 irq masked with ie=0", irq_a, 0);
    cyc(5);
    check("R3 second period count", cnt_a, 5);
    cyc(1);
    check("R3 second wrap", cnt_a, 0);
    wr(2'd0, 8'h10);
    check("R5 irq with ie=1", irq_a, 1);
    cyc(10);
    rd(2'd0, d);
    check("R4 pending sticky", d, 8'h90);
    wr(2'd0, 8'h50);
    rd(2'd0, d);
    check("R4 pending cleared", d, 8'h10);
    check("R5 irq drops after clear", irq_a, 0);
  endtask

  function automatic logic i_pend_a();
    return 1'b0;
  endfunction

  task automatic t_disable_clear;
    logic [7:0] d, held;
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h21 | 8'h06);
    cyc(7);
    wr(2'd0, 8'h10);
    held = cnt_a;
    wr(2'd1, held);
    cyc(30);
    check("R7 counter holds while disabled", cnt_a, held);
    rd(2'd0, d);
    check("R7 no pending while disabled", d[7], 0);
    check("R7 no irq while disabled", irq_a, 0);
    rd(2'd1, d);
    check("R9 reference readback", d, held);
    wr(2'd1, 8'h22);
    rd(2'd1, d);
    check("R9 reference readback 0x22", d, 8'h22);
    wr(2'd0, 8'h70);
    check("R6 clear strobe zeroes counter", cnt_a, 0);
    rd(2'd0, d);
    check("R6 strobes read zero", d, 8'h10);
  endtask

  task automatic t_ext;
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h29);
    cyc(20);
    check("R8 idle pin does not count", cnt_a, 0);
    for (int i = 0; i < 4; i++) begin
      ext_clk_a = 1'b1; cyc(3);
      ext_clk_a = 1'b0; cyc(3);
    end
    cyc(4);
    check("R8 counts external edges", cnt_a, 4);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_timer_b;
    logic [7:0] d, a_hold;
    a_hold = cnt_a;
    wr(2'd3, 8'h03);
    wr(2'd2, 8'h7F);
    rd(2'd2, d);
    check("R10 timer B ignores ext bit", d, 8'h17);
    check("R10 B cleared start", cnt_b, 0);
    cyc(3);
    check("R10 B counts to reference", cnt_b, 3);
    cyc(1);
    check("R3 B wraps", cnt_b, 0);
    check("R5 B irq", irq_b, 1);
    check("R10 A counter untouched", cnt_a, a_hold);
    rd(2'd0, d);
    check("R10 A pending untouched", d[7], 0);
    check("R10 A irq untouched", irq_a, 0);
    rd(2'd3, d);
    check("R9 B reference readback", d, 8'h03);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(5);
    t_reset();
    t_rate(2'b11, 1);
    t_rate(2'b10, 8);
    t_rate(2'b01, 64);
    t_rate(2'b00, 256);
    t_match();
    t_disable_clear();
    t_ext();
    t_timer_b();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
      $finish;
    end
  end
endmodule